// File: doc/BRIEF.md
# UART Interrupt Status Register

This block holds the interrupt status word of a UART controller. Single-cycle event pulses from the receiver, the two FIFOs, the receive timeout counter and the modem-change logic are captured into a 14-bit sticky status field. A bus master reads the field through a 32-bit read port and acknowledges events by writing ones to the bits it wants to clear. One bit is not sticky: it shows the live state of the transmit FIFO trigger comparison.

The status is always kept unmasked, so software may poll it. An interrupt mask input selects which status bits may raise the single registered interrupt output. The delta-modem bit comes out of reset set, so that software checks modem lines after power-up.

Top module: `uart_irq_status`

## Requirements
- R1: `rd_data[31:14]` always reads zero, and `wr_data[31:14]` has no effect on the status.
- R2: After reset `rd_data` is 0x00000200 (only bit 9 set) and `irq_out` is 0.
- R3: An event input high at a clock edge sets its status bit at that edge, and the bit then holds until cleared. Bit map: 13 rx_brk_evt, 12 tx_ovf_evt, 11 tx_nfull_evt, 8 rx_tmo_evt, 7 rx_par_evt, 6 rx_frm_evt, 5 rx_ovf_evt, 4 tx_full_evt, 3 tx_empty_evt, 2 rx_full_evt, 1 rx_empty_evt, 0 rx_trig_evt.
- R4: With `wr_en` high, each status bit whose `wr_data` bit is 1 is cleared at the edge, and bits written 0 keep their value.
- R5: When an event and a write-1 clear hit the same sticky bit in the same cycle, the bit ends set.
- R6: Bit 10 takes the value of `tx_trig_lvl` at each edge and is not changed by writes.
- R7: Bit 9 is sticky and is set when any of `mdm_cts_chg`, `mdm_dsr_chg`, `mdm_ri_trail`, `mdm_dcd_chg` is high. It is cleared by writing 1 to bit 9.
- R8: Status bits are set regardless of `irq_mask`.
- R9: After each edge, `irq_out` equals the OR over bits 13:0 of the new status ANDed with the `irq_mask` value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the clear operation |
| wr_data | input | 32 | Write data, a 1 clears the bit |
| rd_data | output | 32 | Current status word |
| rx_brk_evt | input | 1 | Receiver break detected |
| tx_ovf_evt | input | 1 | Transmit FIFO overflow |
| tx_nfull_evt | input | 1 | Transmit FIFO became nearly full |
| tx_trig_lvl | input | 1 | Transmit fill level at or above the threshold (level) |
| mdm_cts_chg | input | 1 | CTS changed |
| mdm_dsr_chg | input | 1 | DSR changed |
| mdm_ri_trail | input | 1 | Ring indicator trailing edge |
| mdm_dcd_chg | input | 1 | DCD changed |
| rx_tmo_evt | input | 1 | Receive timeout expired |
| rx_par_evt | input | 1 | Parity error |
| rx_frm_evt | input | 1 | Framing error |
| rx_ovf_evt | input | 1 | Receive overflow |
| tx_full_evt | input | 1 | Transmit FIFO became full |
| tx_empty_evt | input | 1 | Transmit FIFO became empty |
| rx_full_evt | input | 1 | Receive FIFO became full |
| rx_empty_evt | input | 1 | Receive FIFO became empty |
| rx_trig_evt | input | 1 | Word pushed into the receive FIFO |
| irq_mask | input | 14 | Per-bit interrupt enable |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The properties assume that every event and modem input is a synchronous level sampled at the rising edge. A pulse held for several cycles counts as one event per cycle, and the properties rely on nothing more. The bench changes all inputs on the falling edge and holds each event high for one cycle. It drives the four modem indicators one at a time and also together. It issues clears with and without colliding events, so the event-over-clear and level-bit cases are reached on purpose.

// File: rtl/uart_isr_pkg.sv
package uart_isr_pkg;
    localparam int STS_W = 14;
    localparam int REG_W = 32;

    localparam int B_RTRIG  = 0;
    localparam int B_REMPTY = 1;
    localparam int B_RFULL  = 2;
    localparam int B_TEMPTY = 3;
    localparam int B_TFULL  = 4;
    localparam int B_ROVR   = 5;
    localparam int B_FRAME  = 6;
    localparam int B_PAR    = 7;
    localparam int B_TMO    = 8;
    localparam int B_MDM    = 9;
    localparam int B_TTRIG  = 10;
    localparam int B_TNFUL  = 11;
    localparam int B_TOVR   = 12;
    localparam int B_BRK    = 13;

    localparam logic [STS_W-1:0] RESET_STS  = STS_W'(1) << B_MDM;
    localparam logic [STS_W-1:0] LIVE_BITS  = STS_W'(1) << B_TTRIG;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic             irq;
    } isr_state_t;
endpackage

// File: rtl/uart_isr_evt_map.sv
module uart_isr_evt_map
    import uart_isr_pkg::*;
(
    input  logic             rx_brk_evt,
    input  logic             tx_ovf_evt,
    input  logic             tx_nfull_evt,
    input  logic             tx_trig_lvl,
    input  logic             mdm_cts_chg,
    input  logic             mdm_dsr_chg,
    input  logic             mdm_ri_trail,
    input  logic             mdm_dcd_chg,
    input  logic             rx_tmo_evt,
    input  logic             rx_par_evt,
    input  logic             rx_frm_evt,
    input  logic             rx_ovf_evt,
    input  logic             tx_full_evt,
    input  logic             tx_empty_evt,
    input  logic             rx_full_evt,
    input  logic             rx_empty_evt,
    input  logic             rx_trig_evt,
    output logic [STS_W-1:0] set_vec,
    output logic [STS_W-1:0] lvl_vec
);
    logic mdm_any;

    always_comb begin
        mdm_any = mdm_cts_chg | mdm_dsr_chg | mdm_ri_trail | mdm_dcd_chg;

        set_vec          = '0;
        set_vec[B_RTRIG]  = rx_trig_evt;
        set_vec[B_REMPTY] = rx_empty_evt;
        set_vec[B_RFULL]  = rx_full_evt;
        set_vec[B_TEMPTY] = tx_empty_evt;
        set_vec[B_TFULL]  = tx_full_evt;
        set_vec[B_ROVR]   = rx_ovf_evt;
        set_vec[B_FRAME]  = rx_frm_evt;
        set_vec[B_PAR]    = rx_par_evt;
        set_vec[B_TMO]    = rx_tmo_evt;
        set_vec[B_MDM]    = mdm_any;
        set_vec[B_TNFUL]  = tx_nfull_evt;
        set_vec[B_TOVR]   = tx_ovf_evt;
        set_vec[B_BRK]    = rx_brk_evt;

        lvl_vec           = '0;
        lvl_vec[B_TTRIG]  = tx_trig_lvl;
    end
endmodule

// File: rtl/uart_isr_cell.sv
module uart_isr_cell #(
    parameter bit LIVE = 1'b0
) (
    input  logic cur,
    input  logic set,
    input  logic lvl,
    input  logic clr,
    output logic nxt
);
    generate
        if (LIVE) begin : g_live
            always_comb nxt = lvl;
        end else begin : g_sticky
            always_comb nxt = set | (cur & ~clr);
        end
    endgenerate
endmodule

// File: rtl/uart_isr_irq.sv
module uart_isr_irq #(
    parameter int W = 14
) (
    input  logic [W-1:0] sts,
    input  logic [W-1:0] mask,
    output logic         req
);
    always_comb req = |(sts & mask);
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_isr_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_brk_evt,
    input  logic              tx_ovf_evt,
    input  logic              tx_nfull_evt,
    input  logic              tx_trig_lvl,
    input  logic              mdm_cts_chg,
    input  logic              mdm_dsr_chg,
    input  logic              mdm_ri_trail,
    input  logic              mdm_dcd_chg,
    input  logic              rx_tmo_evt,
    input  logic              rx_par_evt,
    input  logic              rx_frm_evt,
    input  logic              rx_ovf_evt,
    input  logic              tx_full_evt,
    input  logic              tx_empty_evt,
    input  logic              rx_full_evt,
    input  logic              rx_empty_evt,
    input  logic              rx_trig_evt,
    input  logic [STS_W-1:0]  irq_mask,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - STS_W;

    isr_state_t       st_d, st_q;
    logic [STS_W-1:0] set_vec, lvl_vec, clr_vec, sts_nxt;
    logic             req_nxt;

    uart_isr_evt_map u_map (
        .rx_brk_evt   (rx_brk_evt),
        .tx_ovf_evt   (tx_ovf_evt),
        .tx_nfull_evt (tx_nfull_evt),
        .tx_trig_lvl  (tx_trig_lvl),
        .mdm_cts_chg  (mdm_cts_chg),
        .mdm_dsr_chg  (mdm_dsr_chg),
        .mdm_ri_trail (mdm_ri_trail),
        .mdm_dcd_chg  (mdm_dcd_chg),
        .rx_tmo_evt   (rx_tmo_evt),
        .rx_par_evt   (rx_par_evt),
        .rx_frm_evt   (rx_frm_evt),
        .rx_ovf_evt   (rx_ovf_evt),
        .tx_full_evt  (tx_full_evt),
        .tx_empty_evt (tx_empty_evt),
        .rx_full_evt  (rx_full_evt),
        .rx_empty_evt (rx_empty_evt),
        .rx_trig_evt  (rx_trig_evt),
        .set_vec      (set_vec),
        .lvl_vec      (lvl_vec)
    );

    // only the implemented bits of the write word take part in a clear
    always_comb clr_vec = wr_en ? wr_data[STS_W-1:0] : '0;

    genvar gi;
    generate
        for (gi = 0; gi < STS_W; gi++) begin : g_bit
            uart_isr_cell #(.LIVE(LIVE_BITS[gi])) u_cell (
                .cur (st_q.sts[gi]),
                .set (set_vec[gi]),
                .lvl (lvl_vec[gi]),
                .clr (clr_vec[gi]),
                .nxt (sts_nxt[gi])
            );
        end
    endgenerate

    uart_isr_irq #(.W(STS_W)) u_irq (
        .sts  (sts_nxt),
        .mask (irq_mask),
        .req  (req_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sts = sts_nxt;
        st_d.irq = req_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sts <= RESET_STS;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = {{PAD_W{1'b0}}, st_q.sts};
    assign irq_out = st_q.irq;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
    import uart_isr_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_brk_evt,
    input logic              tx_ovf_evt,
    input logic              tx_nfull_evt,
    input logic              tx_trig_lvl,
    input logic              mdm_cts_chg,
    input logic              mdm_dsr_chg,
    input logic              mdm_ri_trail,
    input logic              mdm_dcd_chg,
    input logic              rx_tmo_evt,
    input logic              rx_par_evt,
    input logic              rx_frm_evt,
    input logic              rx_ovf_evt,
    input logic              tx_full_evt,
    input logic              tx_empty_evt,
    input logic              rx_full_evt,
    input logic              rx_empty_evt,
    input logic              rx_trig_evt,
    input logic [STS_W-1:0]  irq_mask,
    input logic              irq_out
);
    localparam logic [STS_W-1:0] STICKY = ~LIVE_BITS;

    logic [STS_W-1:0] ev;
    logic [STS_W-1:0] wclr;
    always_comb begin
        ev = {rx_brk_evt, tx_ovf_evt, tx_nfull_evt, 1'b0,
              (mdm_cts_chg | mdm_dsr_chg | mdm_ri_trail | mdm_dcd_chg),
              rx_tmo_evt, rx_par_evt, rx_frm_evt, rx_ovf_evt, tx_full_evt,
              tx_empty_evt, rx_full_evt, rx_empty_evt, rx_trig_evt};
        wclr = wr_en ? wr_data[STS_W-1:0] : '0;
    end

    assert_reset_value_R2: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data == 32'h0000_0200 && !irq_out));

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_brk_evt |=> rd_data[13]);

    assert_sticky_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data[STS_W-1:0] & STICKY) ==
                  ((($past(rd_data[STS_W-1:0]) & ~$past(wclr)) | $past(ev)) & STICKY)));

    assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && rx_par_evt) |=> rd_data[7]);

    assert_live_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_data[10] == $past(tx_trig_lvl)));

    assert_modem_delta_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdm_cts_chg || mdm_dsr_chg || mdm_ri_trail || mdm_dcd_chg) |=> rd_data[9]);

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[DATA_W-1:STS_W] == '0));

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == |(rd_data[STS_W-1:0] & $past(irq_mask))));
endmodule

bind uart_irq_status uart_irq_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [13:0] ev = '0;
    logic [3:0]  md = '0;
    logic        trig = 1'b0;
    logic [13:0] irq_mask = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_irq_status dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rx_brk_evt(ev[13]), .tx_ovf_evt(ev[12]), .tx_nfull_evt(ev[11]),
        .tx_trig_lvl(trig),
        .mdm_cts_chg(md[0]), .mdm_dsr_chg(md[1]), .mdm_ri_trail(md[2]), .mdm_dcd_chg(md[3]),
        .rx_tmo_evt(ev[8]), .rx_par_evt(ev[7]), .rx_frm_evt(ev[6]), .rx_ovf_evt(ev[5]),
        .tx_full_evt(ev[4]), .tx_empty_evt(ev[3]), .rx_full_evt(ev[2]),
        .rx_empty_evt(ev[1]), .rx_trig_evt(ev[0]),
        .irq_mask(irq_mask), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        we;
        logic [13:0] wd;
        logic [13:0] evv;
        logic [3:0]  mdv;
        logic        trg;
        logic [13:0] msk;
        logic [13:0] xs;
        logic        xi;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 14'h0000, 14'h0000, 4'h0, 1'b0, 14'h0000, 14'h0200, 1'b0},
        '{1'b0, 14'h0000, 14'h0000, 4'h0, 1'b0, 14'h0200, 14'h0200, 1'b1},
        '{1'b1, 14'h0200, 14'h0000, 4'h0, 1'b0, 14'h0200, 14'h0000, 1'b0},
        '{1'b0, 14'h0000, 14'h2001, 4'h0, 1'b0, 14'h0000, 14'h2001, 1'b0},
        '{1'b1, 14'h0001, 14'h0000, 4'h0, 1'b0, 14'h0000, 14'h2000, 1'b0},
        '{1'b0, 14'h0000, 14'h0000, 4'h4, 1'b1, 14'h0400, 14'h2600, 1'b1},
        '{1'b1, 14'h3FFF, 14'h0080, 4'h0, 1'b1, 14'h0000, 14'h0480, 1'b0},
        '{1'b0, 14'h0000, 14'h0140, 4'h0, 1'b0, 14'h0040, 14'h01C0, 1'b1},
        '{1'b0, 14'h0000, 14'h0000, 4'h0, 1'b0, 14'h0000, 14'h01C0, 1'b0},
        '{1'b0, 14'h0000, 14'h3FFF, 4'h0, 1'b0, 14'h3FFF, 14'h39FF, 1'b1}
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // drive on the falling edge, let one rising edge pass, sample on the next falling edge
    task automatic step(input logic we, input logic [31:0] wd, input logic [13:0] evv,
                        input logic [3:0] mdv, input logic trg, input logic [13:0] msk);
        wr_en = we; wr_data = wd; ev = evv; md = mdv; trig = trg; irq_mask = msk;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ev = '0; md = '0;
    endtask

    initial begin
        #(20 * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R2: reset state while reset is held
        check32("R2", rd_data, 32'h0000_0200);
        check32("R2", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R2", rd_data, 32'h0000_0200);

        // table walk covering R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].we, {18'b0, TBL[i].wd}, TBL[i].evv, TBL[i].mdv, TBL[i].trg, TBL[i].msk);
            check32($sformatf("R3/R4/R5/R6/R7/R8 vec%0d", i), rd_data, {18'b0, TBL[i].xs});
            check32($sformatf("R9 vec%0d", i), {31'b0, irq_out}, {31'b0, TBL[i].xi});
        end

        // R1: upper write bits alone change nothing, upper read bits stay zero
        step(1'b1, 32'hFFFF_C000, 14'h0, 4'h0, 1'b0, 14'h0);
        check32("R1", rd_data, 32'h0000_39FF);
        // R4: full clear
        step(1'b1, 32'hFFFF_FFFF, 14'h0, 4'h0, 1'b0, 14'h0);
        check32("R4", rd_data, 32'h0);

        // R7: each modem indicator alone sets bit 9, then clear it
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 32'h0, 14'h0, 4'(1 << k), 1'b0, 14'h0);
            check32($sformatf("R7 ind%0d", k), rd_data, 32'h0000_0200);
            step(1'b1, 32'h0000_0200, 14'h0, 4'h0, 1'b0, 14'h0);
            check32("R4", rd_data, 32'h0);
        end

        // R6: write to bit 10 does not clear a live level
        step(1'b0, 32'h0, 14'h0, 4'h0, 1'b1, 14'h0);
        step(1'b1, 32'h0000_0400, 14'h0, 4'h0, 1'b1, 14'h0);
        check32("R6", rd_data, 32'h0000_0400);
        step(1'b0, 32'h0, 14'h0, 4'h0, 1'b0, 14'h0);
        check32("R6", rd_data, 32'h0);

        // R3: a pulse is held over idle cycles
        step(1'b0, 32'h0, 14'h1000, 4'h0, 1'b0, 14'h0);
        step(1'b0, 32'h0, 14'h0, 4'h0, 1'b0, 14'h0);
        step(1'b0, 32'h0, 14'h0, 4'h0, 1'b0, 14'h0);
        check32("R3", rd_data, 32'h0000_1000);
        // R9: mask change alone raises irq at the next edge
        step(1'b0, 32'h0, 14'h0, 4'h0, 1'b0, 14'h1000);
        check32("R9", {31'b0, irq_out}, 32'h1);
        step(1'b0, 32'h0, 14'h0, 4'h0, 1'b0, 14'h0FFF);
        check32("R9", {31'b0, irq_out}, 32'h0);

        // R2: reset in mid-run restores the reset word
        rst_n = 1'b0;
        #1;
        check32("R2", rd_data, 32'h0000_0200);
        check32("R2", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_mask = '0;
        @(negedge clk);
        check32("R2", rd_data, 32'h0000_0200);

        summary();
    end
endmodule